// File: doc/BRIEF.md
# Grouped-Field Memory Fetch Sequencer

This block turns a two-bit grouped field from a microprogram word into a complete memory read. Instead of the microprogram carrying separate bits for address load, PC bump, address latch and read strobe, it writes one short code. The sequencer then runs a fixed six-step series on its own. The microprogram can spend the words that follow on work that does not touch the memory path.

There are two kinds of read. An instruction fetch reads at the program-counter address and also produces the incremented PC. A data fetch reads at the address held in a temporary register, and its increment step does nothing. Both kinds use the same step order. Memory returns data after a fixed latency and has no ready signal. The address comes from the MAR output, and the captured word appears on the MDR output.

Top module: `fetch_sequencer`

## Requirements
- R1: When idle, the command field is decoded as follows: 2'b00 does nothing, 2'b01 starts an instruction fetch, 2'b10 starts a data fetch, and 2'b11 does nothing. Neither 2'b00 nor 2'b11 raises busy or any strobe, and neither changes the MAR.
- R2: An instruction fetch copies pc_i, sampled at the edge that accepts the command, into the MAR. The MAR shows this value from step 1 through step 6.
- R3: In step 2 of an instruction fetch, pc_wr_o is high for one cycle and pc_wdata_o equals the fetched PC plus PC_STEP, modulo 2^ADDR_W. A data fetch leaves pc_wr_o low for its whole sequence.
- R4: A data fetch copies temp_i, sampled at the accepting edge, into the MAR. The MAR holds this value through step 6.
- R5: ale_o is a single-cycle pulse in step 3.
- R6: rd_o is high in steps 4 and 5 and low in step 6. The strobes ale_o, rd_o, pc_wr_o and done_o are never high together.
- R7: mem_data_i is captured into the MDR at the end of step 5. The MDR shows it from step 6 on and changes at no other time.
- R8: busy_o is high for exactly six cycles after the accepting edge. done_o is high only in step 6.
- R9: Commands presented while busy_o is high are ignored. They change neither the MAR nor the sequence length, and no sequence follows them.
- R10: While rst_ni is low, busy_o, ale_o, rd_o, pc_wr_o and done_o are low, and the MAR and MDR are zero. This holds even when reset arrives in the middle of a sequence.
- R11: After step 6 the sequencer is idle, and a new command presented on the following cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Grouped command field |
| pc_i | input | ADDR_W | Program counter value |
| temp_i | input | ADDR_W | Temporary address register value |
| mem_data_i | input | DATA_W | Read data from memory, valid in step 5 |
| mar_o | output | ADDR_W | Memory address register, drives the memory address |
| mdr_o | output | DATA_W | Memory data register |
| pc_wdata_o | output | ADDR_W | Incremented PC |
| pc_wr_o | output | 1 | PC write enable, step 2 of an instruction fetch |
| ale_o | output | 1 | Address latch enable pulse |
| rd_o | output | 1 | Memory read strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Final-step pulse |

## Verification
The bench builds the block with ADDR_W=16, DATA_W=24 and PC_STEP=4. Because the address and data widths differ, a swapped or truncated connection between the MAR and MDR paths shows up as a wrong value. The narrow address lets a PC of 16'hFFFE exercise the wrap of the increment. The memory model returns the MAR value with a fixed low byte, and only while the read strobe is high. As a result, a capture taken in the wrong step or from the wrong address gives a visibly wrong MDR value.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'b00,
    CMD_IFETCH = 2'b01,
    CMD_DFETCH = 2'b10,
    CMD_RSVD   = 2'b11
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_BUMP  = 3'd2,
    ST_LATCH = 3'd3,
    ST_RDON  = 3'd4,
    ST_CAPT  = 3'd5,
    ST_RDOFF = 3'd6
  } step_e;
endpackage

// File: rtl/fseq_decode.sv
module fseq_decode
  import fseq_pkg::*;
(
  input  logic [1:0] cmd_i,
  input  logic       idle_i,
  output logic       start_o,
  output logic       insn_o
);
  cmd_e cmd;
  assign cmd = cmd_e'(cmd_i);

  always_comb begin
    start_o = 1'b0;
    insn_o  = 1'b0;
    if (idle_i) begin
      unique case (cmd)
        CMD_IFETCH: begin start_o = 1'b1; insn_o = 1'b1; end
        CMD_DFETCH: start_o = 1'b1;
        default:    start_o = 1'b0;  // none and reserved
      endcase
    end
  end
endmodule

// File: rtl/fseq_step_ctrl.sv
module fseq_step_ctrl
  import fseq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic insn_i,
  output logic idle_o,
  output logic capt_o,
  output logic pc_wr_o,
  output logic ale_o,
  output logic rd_o,
  output logic busy_o,
  output logic done_o
);
  step_e step_q, step_d;
  logic  insn_q;

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      ST_IDLE:  if (start_i) step_d = ST_ADDR;
      ST_ADDR:  step_d = ST_BUMP;
      ST_BUMP:  step_d = ST_LATCH;
      ST_LATCH: step_d = ST_RDON;
      ST_RDON:  step_d = ST_CAPT;
      ST_CAPT:  step_d = ST_RDOFF;
      ST_RDOFF: step_d = ST_IDLE;
      default:  step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IDLE;
      insn_q <= 1'b0;
    end else begin
      step_q <= step_d;
      if (start_i) insn_q <= insn_i;
    end
  end

  assign idle_o  = (step_q == ST_IDLE);
  assign busy_o  = !idle_o;
  assign capt_o  = (step_q == ST_CAPT);
  assign pc_wr_o = (step_q == ST_BUMP) && insn_q;
  assign ale_o   = (step_q == ST_LATCH);
  assign rd_o    = (step_q == ST_RDON) || (step_q == ST_CAPT);
  assign done_o  = (step_q == ST_RDOFF);
endmodule

// File: rtl/fseq_datapath.sv
module fseq_datapath #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int PC_STEP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              insn_i,
  input  logic              capt_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] temp_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mdr_o,
  output logic [ADDR_W-1:0] pc_wdata_o
);
  localparam logic [ADDR_W-1:0] StepV = ADDR_W'(PC_STEP);

  logic [ADDR_W-1:0] mar_q;
  logic [DATA_W-1:0] mdr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mar_q <= '0;
      mdr_q <= '0;
    end else begin
      if (start_i) mar_q <= insn_i ? pc_i : temp_i;
      if (capt_i)  mdr_q <= mem_data_i;
    end
  end

  // MAR holds the PC during an instruction fetch
  assign pc_wdata_o = mar_q + StepV;
  assign mar_o      = mar_q;
  assign mdr_o      = mdr_q;
endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int PC_STEP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cmd_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] temp_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mdr_o,
  output logic [ADDR_W-1:0] pc_wdata_o,
  output logic              pc_wr_o,
  output logic              ale_o,
  output logic              rd_o,
  output logic              busy_o,
  output logic              done_o
);
  logic idle, start, insn, capt;

  fseq_decode u_decode (
    .cmd_i  (cmd_i),
    .idle_i (idle),
    .start_o(start),
    .insn_o (insn)
  );

  fseq_step_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .insn_i (insn),
    .idle_o (idle),
    .capt_o (capt),
    .pc_wr_o(pc_wr_o),
    .ale_o  (ale_o),
    .rd_o   (rd_o),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  fseq_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PC_STEP(PC_STEP)
  ) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .insn_i    (insn),
    .capt_i    (capt),
    .pc_i      (pc_i),
    .temp_i    (temp_i),
    .mem_data_i(mem_data_i),
    .mar_o     (mar_o),
    .mdr_o     (mdr_o),
    .pc_wdata_o(pc_wdata_o)
  );
endmodule

// File: rtl/fetch_sequencer_chk.sv
module fetch_sequencer_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] mar_o,
  input logic [DATA_W-1:0] mdr_o,
  input logic              pc_wr_o,
  input logic              ale_o,
  input logic              rd_o,
  input logic              busy_o,
  input logic              done_o
);
  a_r5_ale_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o && rd_o);

  a_r6_rd_follows_ale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_o) |-> $past(ale_o));

  a_r6_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ale_o, rd_o, pc_wr_o, done_o}));

  a_r6_rd_released_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_o && $past(rd_o));

  a_r3_bump_before_ale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_wr_o |=> ale_o);

  a_r7_mdr_changes_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdr_o) |-> done_o);

  a_r9_mar_held_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mar_o));

  a_r11_done_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  a_r8_strobes_need_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o || rd_o || pc_wr_o || done_o) |-> busy_o);
endmodule

bind fetch_sequencer fetch_sequencer_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .mar_o  (mar_o),
  .mdr_o  (mdr_o),
  .pc_wr_o(pc_wr_o),
  .ale_o  (ale_o),
  .rd_o   (rd_o),
  .busy_o (busy_o),
  .done_o (done_o)
);

// File: tb/fetch_sequencer_bench.sv
module fetch_sequencer_bench;
  localparam int AW = 16;
  localparam int DW = 24;
  localparam int PS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cmd = 2'b00;
  logic [AW-1:0] pc = '0;
  logic [AW-1:0] temp = '0;
  logic [DW-1:0] mem_data;
  logic [AW-1:0] mar;
  logic [DW-1:0] mdr;
  logic [AW-1:0] pc_wdata;
  logic          pc_wr, ale, rd, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  // fixed-latency memory: data only while read strobe is high
  assign mem_data = rd ? {mar, 8'h5A} : '0;

  fetch_sequencer #(.ADDR_W(AW), .DATA_W(DW), .PC_STEP(PS)) u_fetch_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .pc_i(pc), .temp_i(temp),
    .mem_data_i(mem_data), .mar_o(mar), .mdr_o(mdr), .pc_wdata_o(pc_wdata),
    .pc_wr_o(pc_wr), .ale_o(ale), .rd_o(rd), .busy_o(busy), .done_o(done)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_quiet(input string req);
    check(req, "busy", busy, 0);
    check(req, "strobes", {pc_wr, ale, rd, done}, 0);
  endtask

  // runs one sequence; optionally injects a command while busy
  task automatic run_seq(input logic [1:0] c, input logic [AW-1:0] p, input logic [AW-1:0] t,
                         input bit inject);
    logic [AW-1:0] exp_addr;
    logic [DW-1:0] mdr_before;
    bit is_insn;
    is_insn  = (c == 2'b01);
    exp_addr = is_insn ? p : t;
    mdr_before = mdr;
    @(negedge clk);
    cmd = c; pc = p; temp = t;
    @(negedge clk);
    cmd = 2'b00;
    for (int k = 1; k <= 6; k++) begin
      if (inject && k == 2) begin cmd = 2'b10; pc = ~p; temp = ~t; end
      if (inject && k == 5) cmd = 2'b00;
      #1;
      check("R8", $sformatf("busy step %0d", k), busy, 1);
      check(is_insn ? "R2" : "R4", $sformatf("mar step %0d", k), mar, exp_addr);
      check("R3", $sformatf("pc_wr step %0d", k), pc_wr, (is_insn && k == 2));
      if (is_insn && k == 2) check("R3", "pc_wdata", pc_wdata, AW'(p + PS));
      check("R5", $sformatf("ale step %0d", k), ale, (k == 3));
      check("R6", $sformatf("rd step %0d", k), rd, (k == 4 || k == 5));
      check("R8", $sformatf("done step %0d", k), done, (k == 6));
      if (k < 6) check("R7", $sformatf("mdr held step %0d", k), mdr, mdr_before);
      else       check("R7", "mdr captured", mdr, {exp_addr, 8'h5A});
      @(negedge clk);
    end
    #1;
    check("R11", "idle after done", busy, 0);
    if (inject) begin
      @(negedge clk); #1;
      check("R9", "no sequence from injected command", busy, 0);
      check("R9", "mar unchanged by injection", mar, exp_addr);
    end
  endtask

  task automatic t_reset_state;
    #1;
    check("R10", "busy in reset", busy, 0);
    check("R10", "strobes in reset", {pc_wr, ale, rd, done}, 0);
    check("R10", "mar in reset", mar, 0);
    check("R10", "mdr in reset", mdr, 0);
  endtask

  task automatic t_noop(input logic [1:0] c);
    logic [AW-1:0] mar_before;
    mar_before = mar;
    @(negedge clk);
    cmd = c; pc = 16'h1234; temp = 16'h5678;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      check_quiet("R1");
      check("R1", "mar after no-op", mar, mar_before);
    end
    cmd = 2'b00;
  endtask

  task automatic t_back_to_back;
    run_seq(2'b10, 16'h0000, 16'h00F0, 1'b0);
    run_seq(2'b01, 16'h0400, 16'h0000, 1'b0);
  endtask

  task automatic t_mid_reset;
    @(negedge clk);
    cmd = 2'b01; pc = 16'h2222;
    @(negedge clk); cmd = 2'b00;
    @(negedge clk); @(negedge clk); @(negedge clk);
    #1;
    check("R6", "rd before reset", rd, 1);
    rst_n = 1'b0;
    #1;
    check("R10", "busy on mid reset", busy, 0);
    check("R10", "strobes on mid reset", {pc_wr, ale, rd, done}, 0);
    check("R10", "mar on mid reset", mar, 0);
    check("R10", "mdr on mid reset", mdr, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check_quiet("R10");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_noop(2'b00);
    t_noop(2'b11);
    run_seq(2'b01, 16'h0100, 16'hBEEF, 1'b0);
    run_seq(2'b10, 16'h0200, 16'h3C3C, 1'b0);
    run_seq(2'b01, 16'hFFFE, 16'h0000, 1'b0);
    run_seq(2'b01, 16'h0A00, 16'h0B00, 1'b1);
    t_back_to_back();
    t_mid_reset();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule